// File: doc/BRIEF.md
# Packed extend-and-add execution unit

This unit executes one 32-bit data-processing instruction from the register-extend group of a compressed instruction set. It recognises three opcodes: a dual-lane byte sign extension, a halfword sign extension and a halfword zero extension. Each opcode has a form that adds the extended value to a second operand and a form that does not. The register file has already read both source operands and passes them in alongside the instruction word. The unit decodes the word, rotates the extend operand, extends it and adds it where the form requires.

The dual-lane form keeps byte 0 and byte 2 of the rotated operand by masking. It copies their sign bits into the upper byte of each 16-bit lane by multiplying the isolated sign bits by a constant. When it accumulates, it adds the two lanes independently, so no carry crosses between them. A source-index field of all ones selects the non-accumulating form.

Results and flags come out of registers exactly one clock after the input. Words that are not recognised raise a not-recognised flag. Recognised words that name index 15 as the destination or the extend operand raise an unpredictable flag. In both cases the write-enable stays low.

Top module: `xadd_unit`

## Requirements
- R1: Bit positions are fixed. Prefix = bits 31:20, accumulate index = 19:16, destination = 11:8, rotate field = 5:4, extend operand index = 3:0. A word is recognised only when bits 15:12 = 4'hF, bits 7:6 = 2'b10 and the prefix is one of the following. 12'hFA2 is the byte-pair sign extension. 12'hFA0 is the halfword sign extension. 12'hFA1 is the halfword zero extension.
- R2: An accumulate index of 4'hF selects the non-accumulating form. The second operand value then has no effect on the result.
- R3: The extend operand is rotated right by 8 × the rotate field (0, 8, 16 or 24 bits) before extraction.
- R4: In the byte-pair form, rotated byte 0 is sign-extended into result bits 15:0. Rotated byte 2 is sign-extended into result bits 31:16.
- R5: In the accumulating byte-pair form, each extended 16-bit lane is added to the matching lane of the second operand modulo 2^16. No carry passes from bit 15 to bit 16.
- R6: In the halfword forms, rotated bits 15:0 are sign-extended (prefix FA0) or zero-extended (prefix FA1) to 32 bits. In the accumulating form, the extended value is added to the full 32-bit second operand modulo 2^32.
- R7: Suppose a recognised word has destination = 15 or extend operand index = 15. Then the unpredictable flag is set, and the write-enable and the not-recognised flag stay low.
- R8: A valid word that is not recognised sets the not-recognised flag, and the write-enable and the unpredictable flag stay low.
- R9: All outputs are registered one clock after the input. After reset, and in any cycle that follows an input with valid low, the write-enable and both flags are 0.
- R10: When the write-enable is high, the destination index output equals the destination field of the word accepted one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction word and operands are valid this cycle |
| insn | input | 32 | Instruction word |
| rmVal | input | 32 | Value of the extend operand register |
| rnVal | input | 32 | Value of the accumulate operand register |
| rdIdx | output | 4 | Destination register index |
| result | output | 32 | Computed result |
| wrEn | output | 1 | Write the result to the destination register |
| unpred | output | 1 | Recognised word with a forbidden register index |
| illegal | output | 1 | Valid word not recognised by this unit |

## Verification
The bench builds the unit with its default widths: a 32-bit word, 16-bit lanes and 4-bit register indices. These widths give exactly two lanes and four rotation amounts, so every rotation can be combined with sign bits set and clear in both lanes. They also bring the lane boundary at bit 16 within reach of directed overflow operands such as 0x7FFF + 1 and 0xFFFF + 1. At the same width the halfword accumulate forms can show a carry crossing bit 16, which the byte-pair forms must never show.

// File: rtl/xadd_pkg.sv
package xadd_pkg;

  typedef enum logic [1:0] {
    OP_HALF_S = 2'd0,
    OP_HALF_Z = 2'd1,
    OP_PAIR_S = 2'd2,
    OP_NONE   = 2'd3
  } extOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   recog;
    logic   accum;
    logic   blockWr;
    extOp_e op;
  } ctrlStrb_t;

  localparam logic [11:0] PFX_HALF_S = 12'hFA0;
  localparam logic [11:0] PFX_HALF_Z = 12'hFA1;
  localparam logic [11:0] PFX_PAIR_S = 12'hFA2;
  localparam logic [3:0]  FIXED_HI   = 4'hF;
  localparam logic [1:0]  FIXED_LO   = 2'b10;

endpackage

// File: rtl/xadd_ctrl.sv
module xadd_ctrl
  import xadd_pkg::*;
#(
  parameter int INSN_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [INSN_W-1:0] insn,
  output ctrlStrb_t         strb,
  output logic              wrEn,
  output logic              unpred,
  output logic              illegal
);

  localparam logic [IDX_W-1:0] PC_IDX = '1;

  logic [11:0]      prefix;
  logic [IDX_W-1:0] rnField;
  logic [IDX_W-1:0] rdField;
  logic [IDX_W-1:0] rmField;
  logic             fixedOk;

  assign prefix  = insn[31:20];
  assign rnField = insn[19:16];
  assign rdField = insn[11:8];
  assign rmField = insn[3:0];
  assign fixedOk = (insn[15:12] == FIXED_HI) && (insn[7:6] == FIXED_LO);

  always_comb begin
    strb       = '0;
    strb.op    = OP_NONE;
    if (fixedOk) begin
      case (prefix)
        PFX_HALF_S: begin strb.op = OP_HALF_S; strb.recog = 1'b1; end
        PFX_HALF_Z: begin strb.op = OP_HALF_Z; strb.recog = 1'b1; end
        PFX_PAIR_S: begin strb.op = OP_PAIR_S; strb.recog = 1'b1; end
        default:    strb.op = OP_NONE;
      endcase
    end
    strb.accum   = strb.recog && (rnField != PC_IDX);
    strb.blockWr = strb.recog && ((rdField == PC_IDX) || (rmField == PC_IDX));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrEn    <= 1'b0;
      unpred  <= 1'b0;
      illegal <= 1'b0;
    end else begin
      wrEn    <= inValid && strb.recog && !strb.blockWr;
      unpred  <= inValid && strb.recog && strb.blockWr;
      illegal <= inValid && !strb.recog;
    end
  end

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!wrEn && !unpred && !illegal));

  // R7
  pc_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ((insn[11:8] == 4'hF) || (insn[3:0] == 4'hF))) |=> !wrEn);

  // R8
  bad_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (insn[15:12] != 4'hF)) |=> (illegal && !wrEn && !unpred));

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrEn, unpred, illegal}));

endmodule

// File: rtl/xadd_dpath.sv
module xadd_dpath
  import xadd_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int LANE_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [IDX_W-1:0] rdField,
  input  logic [1:0]       rotSel,
  input  logic [XLEN-1:0]  rmVal,
  input  logic [XLEN-1:0]  rnVal,
  output logic [XLEN-1:0]  result,
  output logic [IDX_W-1:0] rdIdx
);

  localparam int BYTE_W = 8;
  localparam int NLANE  = XLEN / LANE_W;
  localparam int SH_W   = $clog2(XLEN) + 1;
  localparam int EXT_W  = LANE_W - BYTE_W;

  function automatic logic [XLEN-1:0] laneMask(input int width, input int offs);
    logic [XLEN-1:0] m;
    m = '0;
    for (int l = 0; l < NLANE; l++)
      for (int b = 0; b < width; b++)
        m[l*LANE_W + offs + b] = 1'b1;
    return m;
  endfunction

  localparam logic [XLEN-1:0] LOW_BYTES = laneMask(BYTE_W, 0);
  localparam logic [XLEN-1:0] SIGN_BITS = laneMask(1, BYTE_W - 1);
  localparam logic [XLEN-1:0] SPREAD    = XLEN'(((1 << EXT_W) - 1) << 1);

  logic [SH_W-1:0] rotAmt;
  logic [XLEN-1:0] rotated;
  logic [XLEN-1:0] maskedBytes;
  logic [XLEN-1:0] signIso;
  logic [XLEN-1:0] pairExt;
  logic [XLEN-1:0] laneSum;
  logic [XLEN-1:0] halfExt;
  logic [XLEN-1:0] halfSum;
  logic [XLEN-1:0] nextRes;
  logic            halfSign;

  assign rotAmt  = SH_W'(rotSel) << 3;
  assign rotated = (rmVal >> rotAmt) | (rmVal << (SH_W'(XLEN) - rotAmt));

  assign maskedBytes = rotated & LOW_BYTES;
  assign signIso     = rotated & SIGN_BITS;
  assign pairExt     = maskedBytes | (signIso * SPREAD);

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign laneSum[g*LANE_W +: LANE_W] =
      pairExt[g*LANE_W +: LANE_W] + rnVal[g*LANE_W +: LANE_W];
  end

  assign halfSign = (strb.op == OP_HALF_S) && rotated[LANE_W-1];
  assign halfExt  = {{(XLEN-LANE_W){halfSign}}, rotated[LANE_W-1:0]};
  assign halfSum  = halfExt + rnVal;

  always_comb begin
    case (strb.op)
      OP_PAIR_S:            nextRes = strb.accum ? laneSum : pairExt;
      OP_HALF_S, OP_HALF_Z: nextRes = strb.accum ? halfSum : halfExt;
      default:              nextRes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
      rdIdx  <= '0;
    end else begin
      result <= nextRes;
      rdIdx  <= rdField;
    end
  end

  for (genvar a = 0; a < NLANE; a++) begin : g_chk
    // R4
    pair_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.recog && (strb.op == OP_PAIR_S) && !strb.accum) |=>
        (result[a*LANE_W+BYTE_W +: EXT_W] == {EXT_W{result[a*LANE_W+BYTE_W-1]}}));
  end

  // R6
  zext_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.recog && (strb.op == OP_HALF_Z) && !strb.accum) |=>
      (result[XLEN-1:LANE_W] == '0));

  // R3
  rot_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.recog && (strb.op == OP_HALF_Z) && !strb.accum && (rotSel == 2'd0)) |=>
      (result[LANE_W-1:0] == $past(rmVal[LANE_W-1:0])));

endmodule

// File: rtl/xadd_unit.sv
module xadd_unit
  import xadd_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int LANE_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [31:0]      insn,
  input  logic [XLEN-1:0]  rmVal,
  input  logic [XLEN-1:0]  rnVal,
  output logic [IDX_W-1:0] rdIdx,
  output logic [XLEN-1:0]  result,
  output logic             wrEn,
  output logic             unpred,
  output logic             illegal
);

  ctrlStrb_t strb;

  xadd_ctrl #(.INSN_W(32), .IDX_W(IDX_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .insn    (insn),
    .strb    (strb),
    .wrEn    (wrEn),
    .unpred  (unpred),
    .illegal (illegal)
  );

  xadd_dpath #(.XLEN(XLEN), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rdField (insn[11:8]),
    .rotSel  (insn[5:4]),
    .rmVal   (rmVal),
    .rnVal   (rnVal),
    .result  (result),
    .rdIdx   (rdIdx)
  );

  // R10
  dest_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (!wrEn || (rdIdx == $past(insn[11:8]))));

  // R7
  no_pc_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (rdIdx != 4'hF));

endmodule

// File: tb/sim_xadd_unit.sv
`timescale 1ns/1ps
module sim_xadd_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] insn = '0;
  logic [31:0] rmVal = '0;
  logic [31:0] rnVal = '0;
  logic [3:0]  rdIdx;
  logic [31:0] result;
  logic        wrEn, unpred, illegal;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xadd_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .insn(insn),
    .rmVal(rmVal), .rnVal(rnVal), .rdIdx(rdIdx), .result(result),
    .wrEn(wrEn), .unpred(unpred), .illegal(illegal)
  );

  typedef struct {
    logic        wr;
    logic        up;
    logic        il;
    logic [31:0] res;
    logic [3:0]  rd;
    string       tag;
  } exp_t;

  exp_t pend[$];

  function automatic logic [31:0] mk(input logic [11:0] pfx, input logic [3:0] rn,
                                     input logic [3:0] rd, input logic [1:0] rr,
                                     input logic [3:0] rm);
    return {pfx, rn, 4'hF, rd, 2'b10, rr, rm};
  endfunction

  // Behavioural reference built from the requirements
  function automatic exp_t model(input logic v, input logic [31:0] w,
                                 input logic [31:0] rm, input logic [31:0] rn,
                                 input string tag);
    exp_t e;
    logic [63:0] dbl;
    logic [31:0] rot;
    logic [31:0] hx;
    int amt;
    bit known, acc;
    e.tag = tag; e.wr = 0; e.up = 0; e.il = 0; e.res = '0; e.rd = w[11:8];
    if (!v) return e;
    known = (w[15:12] == 4'hF) && (w[7:6] == 2'b10) &&
            (w[31:20] == 12'hFA0 || w[31:20] == 12'hFA1 || w[31:20] == 12'hFA2);
    if (!known) begin e.il = 1; return e; end
    if (w[11:8] == 4'hF || w[3:0] == 4'hF) begin e.up = 1; return e; end
    e.wr = 1;
    acc = (w[19:16] != 4'hF);
    amt = 8 * int'(w[5:4]);
    dbl = {rm, rm};
    rot = dbl[amt +: 32];
    if (w[31:20] == 12'hFA2) begin
      for (int l = 0; l < 2; l++) begin
        int lane;
        lane = int'($signed(rot[16*l +: 8]));
        if (acc) lane = lane + int'(rn[16*l +: 16]);
        e.res[16*l +: 16] = lane[15:0];
      end
    end else begin
      if (w[31:20] == 12'hFA0) hx = 32'(int'($signed(rot[15:0])));
      else                     hx = {16'h0, rot[15:0]};
      e.res = acc ? hx + rn : hx;
    end
    return e;
  endfunction

  task automatic checkOut();
    exp_t e;
    if (pend.size() == 0) return;
    e = pend.pop_front();
    checks++;
    if (wrEn !== e.wr || unpred !== e.up || illegal !== e.il ||
        (e.wr && (result !== e.res || rdIdx !== e.rd))) begin
      errors++;
      $display("FAIL %s: got wr=%0b up=%0b il=%0b res=%h rd=%0d, expected wr=%0b up=%0b il=%0b res=%h rd=%0d",
               e.tag, wrEn, unpred, illegal, result, rdIdx,
               e.wr, e.up, e.il, e.res, e.rd);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] w, input logic [31:0] rm,
                      input logic [31:0] rn, input string tag);
    @(negedge clk);
    checkOut();
    inValid = v; insn = w; rmVal = rm; rnVal = rn;
    pend.push_back(model(v, w, rm, rn, tag));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  logic [31:0] pats [4] = '{32'h807F_0180, 32'h7F80_8001, 32'hFFFF_FFFF, 32'h0080_7F00};

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    checks++;
    if (wrEn !== 0 || unpred !== 0 || illegal !== 0) begin
      errors++;
      $display("FAIL R9 reset: got wr=%0b up=%0b il=%0b, expected 0 0 0", wrEn, unpred, illegal);
    end

    // R9 idle cycles with a garbage word
    step(0, 32'hDEAD_BEEF, 32'h1234_5678, 32'h1, "R9 idle");
    step(0, mk(12'hFA2, 4'h1, 4'h2, 2'd0, 4'h3), 32'h80, 32'h1, "R9 idle");

    // R3 R4 R2: every rotation, sign set and clear in both lanes, no accumulate
    for (int r = 0; r < 4; r++)
      for (int p = 0; p < 4; p++)
        step(1, mk(12'hFA2, 4'hF, 4'(p + 1), 2'(r), 4'h4), pats[p], 32'h5555_AAAA,
             "R3 R4 R2 pair plain");

    // R5: accumulate, every rotation
    for (int r = 0; r < 4; r++)
      for (int p = 0; p < 4; p++)
        step(1, mk(12'hFA2, 4'h6, 4'h7, 2'(r), 4'h8), pats[p], 32'h1234_FFF0,
             "R5 pair accum");

    // R5: lane overflow must not cross bit 16
    step(1, mk(12'hFA2, 4'h1, 4'h2, 2'd0, 4'h3), 32'h0001_0001, 32'h7FFF_FFFF, "R5 lane ovf 7FFF/FFFF");
    step(1, mk(12'hFA2, 4'h1, 4'h2, 2'd0, 4'h3), 32'h0001_0001, 32'hFFFF_7FFF, "R5 lane ovf FFFF/7FFF");
    step(1, mk(12'hFA2, 4'h1, 4'h2, 2'd0, 4'h3), 32'h00FF_00FF, 32'h0001_0001, "R5 neg plus one");

    // R6: halfword forms, each rotation, plain and accumulate
    for (int r = 0; r < 4; r++)
      for (int p = 0; p < 4; p++) begin
        step(1, mk(12'hFA0, 4'hF, 4'h9, 2'(r), 4'h1), pats[p], 32'h0F0F_0F0F, "R6 R3 half sext");
        step(1, mk(12'hFA1, 4'hF, 4'hA, 2'(r), 4'h1), pats[p], 32'h0F0F_0F0F, "R6 R3 half zext");
        step(1, mk(12'hFA0, 4'h2, 4'hB, 2'(r), 4'h1), pats[p], 32'h0000_FFFF, "R6 half sext acc");
        step(1, mk(12'hFA1, 4'h2, 4'hC, 2'(r), 4'h1), pats[p], 32'h7FFF_FFFF, "R6 half zext acc");
      end
    // R6: full-width carry crosses bit 16
    step(1, mk(12'hFA1, 4'h2, 4'h3, 2'd0, 4'h1), 32'h0000_0001, 32'h0000_FFFF, "R6 carry 16");

    // R7: protected indices
    step(1, mk(12'hFA2, 4'h1, 4'hF, 2'd0, 4'h3), 32'h80, 32'h1, "R7 dest 15");
    step(1, mk(12'hFA0, 4'hF, 4'h2, 2'd1, 4'hF), 32'h80, 32'h1, "R7 rm 15");

    // R8: unrecognised words
    step(1, mk(12'hFA3, 4'h1, 4'h2, 2'd0, 4'h3), 32'h1, 32'h1, "R8 prefix FA3");
    step(1, {12'hFA2, 4'h1, 4'hE, 4'h2, 2'b10, 2'd0, 4'h3}, 32'h1, 32'h1, "R8 bits15:12");
    step(1, {12'hFA2, 4'h1, 4'hF, 4'h2, 2'b11, 2'd0, 4'h3}, 32'h1, 32'h1, "R8 bits7:6=11");
    step(1, {12'hFA1, 4'h1, 4'hF, 4'h2, 2'b00, 2'd0, 4'h3}, 32'h1, 32'h1, "R8 bits7:6=00");

    // R1 R10: back-to-back destinations, valid gaps
    for (int d = 0; d < 15; d++)
      step(1, mk(12'hFA2 - 12'(d % 3), 4'(d), 4'(d), 2'(d), 4'((d + 5) % 15)),
           32'h9A7C_4E81 ^ 32'(d * 32'h0101_0101), 32'h8001_7FFF, "R1 R10 stream");
    step(0, 32'h0, 32'h0, 32'h0, "R9 idle after");
    step(1, mk(12'hFA2, 4'hF, 4'h5, 2'd2, 4'h6), 32'h80FF_7F00, 32'h0, "R4 after idle");

    @(negedge clk);
    checkOut();
    inValid = 0;
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule